// File: doc/BRIEF.md
# Data Word Error Detect and Correct Unit

This block guards a 16-bit data word with 6 check bits. On the write side it turns the outgoing word into check bits. On the read side it takes the word and check bits that come back. It rebuilds the code, forms a syndrome, repairs a single flipped data bit and raises flags for what it found. A mode input chooses between two schemes. The first is a full single-error-correct, double-error-detect code, with five Hamming bits plus one overall parity bit. The second is plain even parity, which uses check bit 0 only.

The check-bit path and the repaired data are purely combinational. The two error flags are registered once per clock from the read that is presented while the read-valid input is high. The data width is a parameter, and the number of Hamming bits is derived from it. A second parameter chooses registered or combinational flags. The default is registered.

Top module: `edc_unit`

## Requirements
- R1: With `par_mode`=0, `wr_chk[i]` for i in 0..4 is the XOR of every data bit whose codeword position has bit i set. Check bit i sits at position 2^i. Data bits 0..15 take, in ascending order, the positions 3,5,6,7,9,10,11,12,13,14,15,17,18,19,20,21. `wr_chk[5]` is the XOR of all 16 data bits and `wr_chk[4:0]`.
- R2: With `par_mode`=1, `wr_chk[0]` is the XOR of the 16 data bits (even parity) and `wr_chk[5:1]` is 0.
- R3: A read whose word and check bits match the R1 encoding gives `rd_fixed`=`rd_data` and raises neither flag.
- R4: With `par_mode`=0, any single flipped data bit is put right on `rd_fixed` and `err_single` is raised.
- R5: With `par_mode`=0, any single flipped check bit (0..5) leaves `rd_fixed`=`rd_data` and raises `err_single`.
- R6: With `par_mode`=0, any two flipped bits among the 22 raise `err_uncor` only, and `rd_fixed`=`rd_data`. The two flags are never high together.
- R7: With `par_mode`=0, an odd mismatch count with a syndrome above 21 raises `err_uncor` and corrects nothing. A syndrome of 0 with an odd count points at check bit 5.
- R8: With `par_mode`=1, `rd_fixed`=`rd_data` always and `err_single` stays 0. `err_uncor` equals XOR(`rd_data`) XOR `rd_chk[0]`, and `rd_chk[5:1]` has no effect.
- R9: The flags change only at a rising clock edge. They reflect the read present at that edge when `rd_valid`=1, and they are 0 after an edge with `rd_valid`=0 and during reset.
- R10: `rd_fixed` and `wr_chk` follow their inputs within the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_mode | input | 1 | 1 selects even parity, 0 selects correction code |
| wr_data | input | 16 | Word to be protected |
| wr_chk | output | 6 | Check bits for `wr_data` |
| rd_valid | input | 1 | A read is present this cycle |
| rd_data | input | 16 | Received word |
| rd_chk | input | 6 | Received check bits |
| rd_fixed | output | 16 | Repaired word |
| err_single | output | 1 | Corrected (single) error seen |
| err_uncor | output | 1 | Uncorrectable or parity error seen |

## Verification
The properties assume that every input is a known 0 or 1 from the first clock edge after reset on. They also assume that `par_mode` describes the read present at the same edge. The bench drives all inputs at time zero and changes them only at falling edges. It sets the mode together with each read, so each read and its mode reach the same rising edge. The round-trip property assumes the write and read sides present the same word in the same cycle, and the stimulus produces that on purpose for clean reads.

// File: rtl/edc_pkg.sv
package edc_pkg;

   typedef enum logic [1:0] {
      DEC_CLEAN  = 2'd0,
      DEC_SINGLE = 2'd1,
      DEC_UNCOR  = 2'd2
   } dec_cls_e;

   function automatic bit is_pow2(input int v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // smallest r with 2^r >= data bits + r + 1
   function automatic int ham_bits(input int dw);
      int r;
      r = 1;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   // codeword position of data bit j (skips powers of two)
   function automatic int data_pos(input int j);
      int cnt;
      int res;
      cnt = -1;
      res = 0;
      for (int p = 1; p < 256; p++) begin
         if (!is_pow2(p) && (res == 0)) begin
            cnt++;
            if (cnt == j) res = p;
         end
      end
      return res;
   endfunction

   // data bits covered by Hamming bit i
   function automatic logic [63:0] cover_mask(input int dw, input int i);
      logic [63:0] m;
      m = '0;
      for (int j = 0; j < dw; j++)
         m[j] = ((data_pos(j) >> i) & 1) != 0;
      return m;
   endfunction

endpackage

// File: rtl/edc_chk_gen.sv
module edc_chk_gen
   import edc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HAM_W  = 5
) (
   input  logic [DATA_W-1:0] data,
   output logic [HAM_W-1:0]  ham,
   output logic              data_par
);

   generate
      for (genvar i = 0; i < HAM_W; i++) begin : g_ham
         localparam logic [63:0] MASK = cover_mask(DATA_W, i);
         assign ham[i] = ^(data & MASK[DATA_W-1:0]);
      end
   endgenerate

   assign data_par = ^data;

endmodule

// File: rtl/edc_dec_core.sv
module edc_dec_core
   import edc_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int HAM_W  = 5
) (
   input  logic              par_mode,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [HAM_W-1:0]  rd_ham,
   input  logic              rd_ovr,
   input  logic [HAM_W-1:0]  calc_ham,
   input  logic              data_par,
   output logic [DATA_W-1:0] fixed,
   output dec_cls_e          cls
);

   logic [HAM_W-1:0]  syn;
   logic              ovr_mis;
   logic              par_mis;
   logic [DATA_W-1:0] hit;
   logic              any_hit;
   logic              chk_loc;

   assign syn     = calc_ham ^ rd_ham;
   assign ovr_mis = data_par ^ (^rd_ham) ^ rd_ovr;
   assign par_mis = data_par ^ rd_ham[0];
   assign chk_loc = ($countones(syn) <= 1);

   generate
      for (genvar j = 0; j < DATA_W; j++) begin : g_hit
         localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(j));
         assign hit[j] = (syn == POS);
      end
   endgenerate

   assign any_hit = |hit;

   always_comb begin
      if (par_mode) begin
         cls = par_mis ? DEC_UNCOR : DEC_CLEAN;
      end else if (!ovr_mis) begin
         cls = (syn == '0) ? DEC_CLEAN : DEC_UNCOR;
      end else if (any_hit || chk_loc) begin
         cls = DEC_SINGLE;
      end else begin
         cls = DEC_UNCOR;
      end
   end

   assign fixed = rd_data ^ (hit & {DATA_W{ovr_mis && !par_mode}});

endmodule

// File: rtl/edc_status_reg.sv
module edc_status_reg
   import edc_pkg::*;
#(
   parameter bit REG_STATUS = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     valid,
   input  dec_cls_e cls,
   output logic     err_single,
   output logic     err_uncor
);

   logic s_nx;
   logic u_nx;

   assign s_nx = valid && (cls == DEC_SINGLE);
   assign u_nx = valid && (cls == DEC_UNCOR);

   generate
      if (REG_STATUS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               err_single <= 1'b0;
               err_uncor  <= 1'b0;
            end else begin
               err_single <= s_nx;
               err_uncor  <= u_nx;
            end
         end

         AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            !valid |=> (!err_single && !err_uncor)); // R9
      end else begin : g_comb
         assign err_single = s_nx;
         assign err_uncor  = u_nx;
      end
   endgenerate

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(err_single && err_uncor)); // R6

endmodule

// File: rtl/edc_unit.sv
module edc_unit
   import edc_pkg::*;
#(
   parameter int  DATA_W     = 16,
   parameter bit  REG_STATUS = 1'b1,
   localparam int HAM_W      = ham_bits(DATA_W),
   localparam int CHK_W      = HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              par_mode,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CHK_W-1:0]  wr_chk,
   input  logic              rd_valid,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [CHK_W-1:0]  rd_chk,
   output logic [DATA_W-1:0] rd_fixed,
   output logic              err_single,
   output logic              err_uncor
);

   initial begin
      AST_CFG_WIDTH: assert (DATA_W >= 2 && DATA_W <= 57)
         else $error("edc_unit: DATA_W out of range"); // R1
   end

   // write side
   logic [HAM_W-1:0] w_ham;
   logic             w_par;

   edc_chk_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_wgen (
      .data     (wr_data),
      .ham      (w_ham),
      .data_par (w_par)
   );

   assign wr_chk = par_mode ? {{HAM_W{1'b0}}, w_par}
                            : {w_par ^ (^w_ham), w_ham};

   // read side
   logic [HAM_W-1:0] r_ham;
   logic             r_par;
   dec_cls_e         cls;

   edc_chk_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_rgen (
      .data     (rd_data),
      .ham      (r_ham),
      .data_par (r_par)
   );

   edc_dec_core #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_dec (
      .par_mode (par_mode),
      .rd_data  (rd_data),
      .rd_ham   (rd_chk[HAM_W-1:0]),
      .rd_ovr   (rd_chk[CHK_W-1]),
      .calc_ham (r_ham),
      .data_par (r_par),
      .fixed    (rd_fixed),
      .cls      (cls)
   );

   edc_status_reg #(.REG_STATUS(REG_STATUS)) u_stat (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid      (rd_valid),
      .cls        (cls),
      .err_single (err_single),
      .err_uncor  (err_uncor)
   );

   AST_PAR_NO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
      par_mode |-> (rd_fixed == rd_data)); // R8

   AST_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(rd_fixed ^ rd_data) <= 1); // R4

   generate
      if (REG_STATUS) begin : g_flag_chk
         AST_ROUNDTRIP: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && rd_data == wr_data && rd_chk == wr_chk)
            |=> (!err_single && !err_uncor)); // R3

         AST_FIX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && rd_fixed != rd_data) |=> err_single); // R4

         AST_PAR_NO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && par_mode) |=> !err_single); // R8
      end
   endgenerate

endmodule

// File: tb/sim_edc_unit.sv
module sim_edc_unit;

   localparam int CLK_P    = 10;
   localparam int WD_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        par_mode = 1'b0;
   logic [15:0] wr_data = '0;
   logic [5:0]  wr_chk;
   logic        rd_valid = 1'b0;
   logic [15:0] rd_data = '0;
   logic [5:0]  rd_chk = '0;
   logic [15:0] rd_fixed;
   logic        err_single;
   logic        err_uncor;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 0;
   int posv[16];

   always #(CLK_P/2) clk = ~clk;

   edc_unit u0 (
      .clk(clk), .rst_n(rst_n), .par_mode(par_mode),
      .wr_data(wr_data), .wr_chk(wr_chk),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk),
      .rd_fixed(rd_fixed), .err_single(err_single), .err_uncor(err_uncor)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tg);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tg, act, exp);
      end
   endtask

   function automatic bit pow2(input int v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic logic [5:0] enc(input logic [15:0] d);
      logic [5:0] c;
      c = '0;
      for (int i = 0; i < 5; i++)
         for (int j = 0; j < 16; j++)
            if (((posv[j] >> i) & 1) != 0) c[i] = c[i] ^ d[j];
      c[5] = (^d) ^ (^c[4:0]);
      return c;
   endfunction

   // expected outcome from the error pattern e: [15:0] data, [21:16] check bits
   task automatic model(input logic [15:0] d, input logic [21:0] e,
                        output logic [15:0] rdv, output logic [5:0] rcv,
                        output logic [15:0] ef, output logic es, output logic eu);
      int s;
      s = 0;
      rdv = d ^ e[15:0];
      rcv = enc(d) ^ e[21:16];
      for (int j = 0; j < 16; j++) if (e[j]) s = s ^ posv[j];
      for (int i = 0; i < 5; i++) if (e[16+i]) s = s ^ (1 << i);
      ef = rdv; es = 1'b0; eu = 1'b0;
      if (!(^e)) begin
         eu = (s != 0);
      end else if (s == 0 || pow2(s)) begin
         es = 1'b1;
      end else if (s <= 21) begin
         es = 1'b1;
         for (int j = 0; j < 16; j++) if (posv[j] == s) ef[j] = ~ef[j];
      end else begin
         eu = 1'b1;
      end
   endtask

   task automatic do_read(input logic [15:0] d, input logic [5:0] c, input logic pm,
                          input logic [15:0] ef, input logic es, input logic eu,
                          input string tg);
      @(negedge clk);
      rd_data = d; rd_chk = c; par_mode = pm; rd_valid = 1'b1;
      #1;
      chk({16'h0, rd_fixed}, {16'h0, ef}, {tg, " rd_fixed (R10 same cycle)"});
      @(posedge clk);
      #1;
      chk({31'h0, err_single}, {31'h0, es}, {tg, " err_single"});
      chk({31'h0, err_uncor},  {31'h0, eu}, {tg, " err_uncor"});
   endtask

   task automatic finish_run();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WD_LIMIT);
         finish_run();
      end
   end

   logic [15:0] words[12];

   initial begin
      logic [15:0] rdv, ef;
      logic [5:0]  rcv;
      logic        es, eu;
      int p;
      p = 1;
      for (int j = 0; j < 16; j++) begin
         while (pow2(p)) p++;
         posv[j] = p;
         p++;
      end
      words[0] = 16'h0000; words[1] = 16'hFFFF; words[2] = 16'hAAAA;
      words[3] = 16'h5555; words[4] = 16'h8001; words[5] = 16'h1234;
      words[6] = 16'hBEEF; words[7] = 16'h0F0F; words[8] = 16'h7FFE;
      words[9] = 16'hC3A5; words[10] = 16'h0100; words[11] = 16'hE001;

      repeat (3) @(negedge clk);
      // reset state, R9
      chk({30'h0, err_single, err_uncor}, 32'h0, "R9 reset flags");
      rst_n = 1'b1;

      // R1 / R2 exhaustive encode sweep, R10 no clock needed
      for (int v = 0; v < 65536; v++) begin
         wr_data = 16'(v);
         par_mode = 1'b0;
         #1;
         chk({26'h0, wr_chk}, {26'h0, enc(16'(v))}, "R1 encode");
         par_mode = 1'b1;
         #1;
         chk({26'h0, wr_chk}, {26'h0, 5'h0, ^(16'(v))}, "R2 parity encode");
      end
      par_mode = 1'b0;

      // clean, single and double patterns on fixed words
      foreach (words[w]) begin
         model(words[w], 22'h0, rdv, rcv, ef, es, eu);
         wr_data = words[w];
         do_read(rdv, rcv, 1'b0, ef, es, eu, "R3 clean");
         for (int a = 0; a < 22; a++) begin
            model(words[w], 22'(1) << a, rdv, rcv, ef, es, eu);
            do_read(rdv, rcv, 1'b0, ef, es, eu, (a < 16) ? "R4 single data" : "R5 single check");
            for (int b = a + 1; b < 22; b++) begin
               model(words[w], (22'(1) << a) | (22'(1) << b), rdv, rcv, ef, es, eu);
               do_read(rdv, rcv, 1'b0, ef, es, eu, "R6 double");
            end
         end
      end

      // triple errors, includes syndromes above 21
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] d;
         logic [21:0] e;
         int a, b, c;
         d = 16'($urandom);
         a = $urandom_range(0, 21);
         b = (a + 1 + $urandom_range(0, 19)) % 22;
         do c = $urandom_range(0, 21); while (c == a || c == b);
         e = (22'(1) << a) | (22'(1) << b) | (22'(1) << c);
         model(d, e, rdv, rcv, ef, es, eu);
         do_read(rdv, rcv, 1'b0, ef, es, eu, "R7 triple");
      end

      // parity mode reads, upper check bits random
      for (int k = 0; k < 3000; k++) begin
         logic [15:0] d, r;
         logic [5:0] c;
         d = 16'($urandom);
         r = (k % 3 == 0) ? d : d ^ 16'($urandom);
         c = {5'($urandom), ^d};
         do_read(r, c, 1'b1, r, 1'b0, (^r) ^ c[0], "R8 parity read");
      end

      // rd_valid low: erroneous input is ignored by the flags, R9
      @(negedge clk);
      par_mode = 1'b0; rd_valid = 1'b0;
      rd_data = 16'h1234; rd_chk = enc(16'h1234) ^ 6'h03;
      @(posedge clk); #1;
      chk({30'h0, err_single, err_uncor}, 32'h0, "R9 idle flags");
      // flags hold between edges, R9
      @(negedge clk);
      rd_valid = 1'b1; rd_data = 16'h1234 ^ 16'h0010; rd_chk = enc(16'h1234);
      #1;
      chk({30'h0, err_single, err_uncor}, 32'h0, "R9 no change before edge");
      @(posedge clk); #1;
      chk({30'h0, err_single, err_uncor}, 32'h2, "R9 flag after edge");

      finish_run();
   end

endmodule